// File: doc/BRIEF.md
# Power-State Protocol Monitor

This block sits beside a power controller and watches, every clock, the control lines it drives to a set of switchable domains: per-domain supply enable, isolation on and off commands, state save and restore strobes, and an indicator that a domain's gated clock or reset toggled. It also watches a register-access strobe with the domain it targets, and the encoded power state of the system. Each protocol rule it knows about has its own sticky error bit. The bits stay set until `clr_err` is pulsed, so a regression can read them once at the end of a test.

For coverage, the monitor keeps one saturating hit counter for each power-state code and one for each ordered pair of source and destination states. Transitions that the `LEGAL_MAP` parameter does not allow are still counted, and they also raise an error. Moving into or out of a state that is marked illegal in `BAD_ST` is reported on two separate error bits. The block only observes. It never drives the controller or corrects a violation.

Top module: `pwr_protocol_monitor`

## Requirements
- R1: Error bit 0 is set in the cycle after any bit of `pwr_en`, `iso_on`, `iso_off`, `save` or `restore` is unknown or high-impedance.
- R2: `state_hits` slice s (bits s*CW upward) counts the cycles in which state s is entered: the first sampled state after reset, and every later cycle in which `pstate` differs from its previous value.
- R3: `trans_hits` slice src*NST+dst counts the changes of `pstate` from src to dst.
- R4: Error bit 1 is set when `pstate` changes from src to dst and bit src*NST+dst of `LEGAL_MAP` is 0.
- R5: Error bit 2 is set when `pstate` moves from a code with a 0 in `BAD_ST` to a code with a 1.
- R6: Error bit 3 is set when `pstate` moves from a code with a 1 in `BAD_ST` to a code with a 0.
- R7: Error bit 4 is set when more than one bit of `pwr_en` changes between two consecutive cycles after reset.
- R8: A domain becomes isolated on `iso_on` and stops being isolated on `iso_off`. `iso_on` for a domain that is already isolated sets error bit 5.
- R9: Error bit 6 is set when `reg_acc` is high and the `pwr_en` bit of domain `reg_dom` is low.
- R10: Error bit 7 is set when a `clk_act` bit is high while the same domain's `pwr_en` bit is low.
- R11: Error bits remain set until `clr_err` is high. A violation in the same cycle as `clr_err` still sets its bit.
- R12: Each hit counter stops at 2^CW-1 and does not wrap.
- R13: While reset is asserted, all error bits and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_err | input | 1 | Clears all sticky error bits |
| pwr_en | input | NDOM | Supply enable per domain, 1 means powered |
| iso_on | input | NDOM | Isolation activation command per domain |
| iso_off | input | NDOM | Isolation release command per domain |
| save | input | NDOM | Retention save strobe per domain |
| restore | input | NDOM | Retention restore strobe per domain |
| clk_act | input | NDOM | Gated clock or reset activity seen in a domain |
| reg_acc | input | 1 | Register access strobe |
| reg_dom | input | DW | Domain targeted by the register access |
| pstate | input | SW | Current system power-state code |
| err | output | 8 | Sticky error bits, bit positions as in R1 and R4 to R10 |
| state_hits | output | NST*CW | Per-state entry counters |
| trans_hits | output | NST*NST*CW | Per-transition counters |

## Verification
Every result is registered once. A stimulus applied after rising edge k is captured at edge k+1, and the error bit or counter it affects shows its new value from that edge onward. The bench drives its inputs just after a rising edge. It updates its behavioural model at the next rising edge from the same input values, and compares all error bits and every counter slice at the falling edge between. In that way each comparison looks at the first cycle in which the result is due.

// File: rtl/pwr_protocol_monitor.sv
module pwr_protocol_monitor #(
  parameter int NDOM = 4,
  parameter int NST  = 4,
  parameter int CW   = 8,
  parameter logic [NST*NST-1:0] LEGAL_MAP = 16'h0354,
  parameter logic [NST-1:0] BAD_ST = 4'b1000,
  localparam int SW = (NST > 1) ? $clog2(NST) : 1,
  localparam int DW = (NDOM > 1) ? $clog2(NDOM) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_err,
  input  logic [NDOM-1:0]       pwr_en,
  input  logic [NDOM-1:0]       iso_on,
  input  logic [NDOM-1:0]       iso_off,
  input  logic [NDOM-1:0]       save,
  input  logic [NDOM-1:0]       restore,
  input  logic [NDOM-1:0]       clk_act,
  input  logic                  reg_acc,
  input  logic [DW-1:0]         reg_dom,
  input  logic [SW-1:0]         pstate,
  output logic [7:0]            err,
  output logic [NST*CW-1:0]     state_hits,
  output logic [NST*NST*CW-1:0] trans_hits
);
  localparam logic [CW-1:0] CMAX = '1;

  logic            started;
  logic [SW-1:0]   prev_st;
  logic [NDOM-1:0] pwr_q, iso_q;
  logic [7:0]      viol;

  wire moved = started && (pstate != prev_st);
  wire entered = !started || moved;
  wire [31:0] tidx = 32'(prev_st) * NST + 32'(pstate);

  assign viol[0] = $isunknown({pwr_en, iso_on, iso_off, save, restore});
  assign viol[1] = moved && !LEGAL_MAP[tidx];
  assign viol[2] = moved && BAD_ST[pstate] && !BAD_ST[prev_st];
  assign viol[3] = moved && BAD_ST[prev_st] && !BAD_ST[pstate];
  assign viol[4] = started && ($countones(pwr_en ^ pwr_q) > 1);
  assign viol[5] = |(iso_on & iso_q);
  assign viol[6] = reg_acc && !pwr_en[reg_dom];
  assign viol[7] = |(clk_act & ~pwr_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      prev_st <= '0;
      pwr_q   <= '0;
      iso_q   <= '0;
      err     <= '0;
    end else begin
      started <= 1'b1;
      prev_st <= pstate;
      pwr_q   <= pwr_en;
      iso_q   <= (iso_q | iso_on) & ~iso_off;
      err     <= (clr_err ? 8'h00 : err) | viol;
    end
  end

  for (genvar s = 0; s < NST; s++) begin : g_state
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else if (entered && pstate == SW'(s) && cnt != CMAX) cnt <= cnt + 1'b1;
    end
    assign state_hits[s*CW +: CW] = cnt;

    // R12
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt == CMAX |=> cnt == CMAX);
  end

  for (genvar t = 0; t < NST*NST; t++) begin : g_trans
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else if (moved && tidx == 32'(t) && cnt != CMAX) cnt <= cnt + 1'b1;
    end
    assign trans_hits[t*CW +: CW] = cnt;

    // R3
    trans_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      started |=> cnt >= $past(cnt));
  end

  // R11
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_err |=> (err & $past(err)) == $past(err));

  // R9
  off_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_acc && !pwr_en[reg_dom] |=> err[6]);

  // R10
  off_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(clk_act & ~pwr_en) |=> err[7]);

  // R7
  multi_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started && $countones(pwr_en ^ $past(pwr_en)) > 1 |=> err[4]);

  // R4
  bad_trans_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started && pstate != prev_st && !LEGAL_MAP[tidx] |=> err[1]);
endmodule

// File: tb/pwr_protocol_monitor_test.sv
`timescale 1ns/1ps
module pwr_protocol_monitor_test;
  localparam int NDOM = 4, NST = 4, CW = 4;
  localparam logic [15:0] LEGAL = 16'h0354;
  localparam logic [3:0]  BAD   = 4'b1000;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 0, rst_n = 0, clr_err = 0, reg_acc = 0;
  logic [3:0] pwr_en = 0, iso_on = 0, iso_off = 0, save = 0, restore = 0, clk_act = 0;
  logic [1:0] reg_dom = 0, pstate = 0;
  logic [7:0] err;
  logic [NST*CW-1:0] state_hits;
  logic [NST*NST*CW-1:0] trans_hits;

  pwr_protocol_monitor #(.NDOM(NDOM), .NST(NST), .CW(CW), .LEGAL_MAP(LEGAL), .BAD_ST(BAD)) uut (
    .clk(clk), .rst_n(rst_n), .clr_err(clr_err), .pwr_en(pwr_en), .iso_on(iso_on),
    .iso_off(iso_off), .save(save), .restore(restore), .clk_act(clk_act),
    .reg_acc(reg_acc), .reg_dom(reg_dom), .pstate(pstate),
    .err(err), .state_hits(state_hits), .trans_hits(trans_hits));

  always #4 clk = ~clk;

  int runs = 0, fails = 0, edges = 0;
  int sh[NST];
  int th[NST][NST];
  logic [7:0] m_err;
  logic [1:0] m_prev;
  bit m_started;
  logic [3:0] m_pq, m_iso;
  string etag[8] = '{"R1", "R4", "R5", "R6", "R7", "R8", "R9", "R10"};

  task automatic chk(bit ok, string tag, longint act, longint exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    edges++;
    if (!rst_n) begin
      foreach (sh[i]) sh[i] = 0;
      foreach (th[i, j]) th[i][j] = 0;
      m_err = 0; m_prev = 0; m_started = 0; m_pq = 0; m_iso = 0;
    end else begin
      automatic logic [7:0] v = 0;
      automatic bit moved = m_started && (pstate != m_prev);
      automatic int nch = 0;
      if ($isunknown({pwr_en, iso_on, iso_off, save, restore})) v[0] = 1;
      if (moved) begin
        if (!LEGAL[m_prev*NST + pstate]) v[1] = 1;
        if (BAD[pstate] && !BAD[m_prev]) v[2] = 1;
        if (BAD[m_prev] && !BAD[pstate]) v[3] = 1;
        if (th[m_prev][pstate] < MAXC) th[m_prev][pstate]++;
      end
      if ((!m_started || moved) && sh[pstate] < MAXC) sh[pstate]++;
      for (int d = 0; d < NDOM; d++) begin
        if (pwr_en[d] != m_pq[d]) nch++;
        if (iso_on[d] && m_iso[d]) v[5] = 1;
        if (clk_act[d] && !pwr_en[d]) v[7] = 1;
        if (iso_off[d]) m_iso[d] = 0;
        else if (iso_on[d]) m_iso[d] = 1;
      end
      if (m_started && nch > 1) v[4] = 1;
      if (reg_acc && !pwr_en[reg_dom]) v[6] = 1;
      m_err = (clr_err ? 8'h00 : m_err) | v;
      m_prev = pstate; m_pq = pwr_en; m_started = 1;
    end
  end

  always @(negedge clk) begin
    if (edges > 0) begin
      if (!rst_n) begin
        chk(err == 0, "R13", err, 0);
        chk(state_hits == 0 && trans_hits == 0, "R13", state_hits, 0);
      end else begin
        for (int b = 0; b < 8; b++) chk(err[b] == m_err[b], etag[b], err[b], m_err[b]);
        chk(err == m_err, "R11", err, m_err);
        for (int s = 0; s < NST; s++)
          chk(state_hits[s*CW +: CW] == sh[s], sh[s] == MAXC ? "R12" : "R2",
              state_hits[s*CW +: CW], sh[s]);
        for (int a = 0; a < NST; a++)
          for (int b = 0; b < NST; b++)
            chk(trans_hits[(a*NST+b)*CW +: CW] == th[a][b], th[a][b] == MAXC ? "R12" : "R3",
                trans_hits[(a*NST+b)*CW +: CW], th[a][b]);
      end
    end
  end

  task automatic go(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    go(3);
    rst_n = 1;
    go(2);
    pwr_en = 4'b0001; pstate = 2; go(1);   // R2 R3 legal move, one rail
    pstate = 1; go(1);
    pstate = 2; go(1);
    pstate = 3; go(1);                     // R4 R5
    pstate = 0; go(1);                     // R4 R6
    pstate = 1; go(1);                     // R4 not in map
    clr_err = 1; go(1); clr_err = 0; go(1);
    pwr_en = 4'b0111; go(1);               // R7 two rails
    pwr_en = 4'b0110; go(1);
    clr_err = 1; go(1); clr_err = 0;
    iso_on = 4'b0010; go(1); iso_on = 0; go(1);
    iso_on = 4'b0010; go(1); iso_on = 0;   // R8 redundant
    iso_off = 4'b0010; go(1); iso_off = 0;
    iso_on = 4'b0010; go(1); iso_on = 0;   // R8 legal again
    reg_acc = 1; reg_dom = 1; go(1);       // R9 powered target
    reg_dom = 0; go(1); reg_acc = 0;       // R9 off target
    clk_act = 4'b0100; go(1);              // R10 on domain
    clk_act = 4'b1000; go(1); clk_act = 0; // R10 off domain
    clr_err = 1; reg_acc = 1; reg_dom = 3; go(1); // R11 clear and hit together
    clr_err = 0; reg_acc = 0; go(1);
    save = 'x; go(1); save = 0; go(1);     // R1
    for (int i = 0; i < 40; i++) begin     // R12
      pstate = (i % 2 == 0) ? 2'd2 : 2'd1;
      go(1);
    end
    go(3);
    finish_run();
  end
endmodule